// File: doc/BRIEF.md
# Five-Stage Integer Pipeline Core

This block is a 32-bit in-order integer core with a fixed five-step flow: fetch, decode, execute, memory access and write-back. Each step takes one clock, and one new instruction may start every clock. The instruction word moves along a chain of four instruction registers, one per stage after fetch. The datapath registers travel beside that chain. There is no hazard interlock. ALU results are forwarded into the execute stage, and load results are forwarded once they reach write-back. Any remaining load-use distance and the single branch delay slot are left to the program.

The core fetches from a word-addressed instruction memory and uses a byte-addressed data memory with combinational read and a write strobe. A retire trace shows every instruction that leaves write-back, so an external checker can rebuild the register file history. Branches and jumps resolve in decode and are dropped from the chain at that point. They therefore never reach execute, memory access or the trace.

Instruction layout: opcode in bits [31:26], with the class in [31:29] and a sub-code in [28:26]. Source register S in [25:21], register T in [20:16], destination D in [15:11], and a signed 16-bit immediate in [15:0].

Top module: `pipe5_core`

## Requirements
- R1: After reset, `imem_addr` advances by one word each clock, and the word present on `imem_data` enters decode on that edge. An instruction fetched at edge k appears on the retire trace after edge k+3.
- R2: While reset is low and in the first cycle after it is released, `imem_addr` is 0, `rt_valid` is 0 and `dmem_we` is 0. The next three edges after release produce no retire.
- R3: Class 000 writes register D with S op T. The sub-code selects the operation: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 signed less-than (result 1 or 0), 6 shift left by T[4:0], 7 logical shift right by T[4:0]. The all-zero word is the bubble and is never reported as retired.
- R4: Class 001 writes register T with S op sign-extended immediate, using the R3 sub-codes.
- R5: Class 010 loads the data memory word at S plus the sign-extended immediate into register T. A consumer placed two or more instructions later sees the loaded value.
- R6: Class 011 drives `dmem_we` high for one cycle, with address S plus the sign-extended immediate and data register T. It retires with `rt_we` low.
- R7: Class 100 resolves in decode. Sub-code 0 always jumps, 1 jumps when S equals T, and 2 jumps when they differ. The target is the address after the branch plus four times the immediate. The one following instruction (the delay slot) always executes, and a control word never retires.
- R8: An execute-stage operand takes the ALU result of the instruction one ahead of it, else the result of the instruction two ahead. The nearer producer wins when both target the same register.
- R9: A register written in write-back is read with its new value by decode in the same clock.
- R10: Register 0 reads as zero and writes to it are discarded, reported as a retire with `rt_we` low.
- R11: The retire trace reports instructions in program order. `rt_we` is high, `rt_reg` gives the destination and `rt_data` gives the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 30 | Word address of the fetch |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Data read at `dmem_addr` |
| dmem_we | output | 1 | Store strobe |
| rt_valid | output | 1 | An instruction retires this cycle |
| rt_we | output | 1 | The retiring instruction writes a register |
| rt_reg | output | 5 | Destination of the retiring instruction |
| rt_data | output | 32 | Value written by the retiring instruction |

## Verification
Two events can land in the same clock. In the first, write-back updates a register that decode is reading in that cycle. The program provokes this by placing a consumer exactly three instructions after its producer, with filler between them, and the consumer's traced result must equal the new value. In the second, the two instructions ahead of an ALU instruction in execute both target its source register. A pair of back-to-back writes to one register followed by a reader provokes this, and the trace must show the sum built from the nearer value. Both results are judged against a hand-computed table of expected retire entries, walked in order.

// File: rtl/pipe5_core.sv
module pipe5_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [29:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata,
  output logic        dmem_we,
  output logic        rt_valid,
  output logic        rt_we,
  output logic [4:0]  rt_reg,
  output logic [31:0] rt_data
);
  localparam logic [31:0] BUBBLE = 32'h0;
  localparam logic [2:0] C_ALU = 3'b000, C_ALUI = 3'b001, C_LD = 3'b010,
                         C_ST = 3'b011, C_CTL = 3'b100;

  logic [31:0] pc, ir, ir1, ir2, ir3;
  logic [31:0] opa, opb, aluout, smdr, aluout1, lmdr;
  logic [31:0] rf [0:31];

  function automatic logic [4:0] dest(input logic [31:0] w);
    case (w[31:29])
      C_ALU:        dest = w[15:11];
      C_ALUI, C_LD: dest = w[20:16];
      default:      dest = 5'd0;
    endcase
  endfunction

  // write-back
  logic [4:0]  wb_dst;
  logic [31:0] wb_val;
  logic        wb_en;
  assign wb_dst = dest(ir3);
  assign wb_val = (ir3[31:29] == C_LD) ? lmdr : aluout1;
  assign wb_en  = wb_dst != 5'd0;

  always_ff @(posedge clk)
    if (wb_en) rf[wb_dst] <= wb_val;

  // decode: register read with write-first
  logic [4:0]  s_id, t_id;
  logic [31:0] s_val, t_val, target;
  logic        is_ctl, take;
  assign s_id  = ir[25:21];
  assign t_id  = ir[20:16];
  assign s_val = (s_id == 5'd0) ? 32'd0 : (wb_en && wb_dst == s_id) ? wb_val : rf[s_id];
  assign t_val = (t_id == 5'd0) ? 32'd0 : (wb_en && wb_dst == t_id) ? wb_val : rf[t_id];
  assign is_ctl = ir[31:29] == C_CTL;
  assign take = is_ctl && ((ir[28:26] == 3'd0) ||
                           (ir[28:26] == 3'd1 && s_val == t_val) ||
                           (ir[28:26] == 3'd2 && s_val != t_val));
  assign target = pc + {{14{ir[15]}}, ir[15:0], 2'b00};

  // execute with forwarding
  logic        mem_fw;
  logic [4:0]  mem_dst;
  logic [31:0] fa, fb, op2, res, imm;
  logic [2:0]  aop;
  assign mem_dst = dest(ir2);
  assign mem_fw  = (ir2[31:29] == C_ALU || ir2[31:29] == C_ALUI) && mem_dst != 5'd0;
  assign fa = (mem_fw && mem_dst == ir1[25:21]) ? aluout :
              (wb_en && wb_dst == ir1[25:21]) ? wb_val : opa;
  assign fb = (mem_fw && mem_dst == ir1[20:16]) ? aluout :
              (wb_en && wb_dst == ir1[20:16]) ? wb_val : opb;
  assign imm = {{16{ir1[15]}}, ir1[15:0]};
  assign op2 = (ir1[31:29] == C_ALU) ? fb : imm;
  assign aop = (ir1[31:30] == 2'b00) ? ir1[28:26] : 3'd0;

  always_comb begin
    case (aop)
      3'd0: res = fa + op2;
      3'd1: res = fa - op2;
      3'd2: res = fa & op2;
      3'd3: res = fa | op2;
      3'd4: res = fa ^ op2;
      3'd5: res = {31'd0, $signed(fa) < $signed(op2)};
      3'd6: res = fa << op2[4:0];
      default: res = fa >> op2[4:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 32'd0;
      ir <= BUBBLE; ir1 <= BUBBLE; ir2 <= BUBBLE; ir3 <= BUBBLE;
      opa <= 32'd0; opb <= 32'd0; aluout <= 32'd0; smdr <= 32'd0;
      aluout1 <= 32'd0; lmdr <= 32'd0;
    end else begin
      pc      <= take ? target : pc + 32'd4;
      ir      <= imem_data;
      ir1     <= is_ctl ? BUBBLE : ir;
      opa     <= s_val;
      opb     <= t_val;
      ir2     <= ir1;
      aluout  <= res;
      smdr    <= fb;
      ir3     <= ir2;
      aluout1 <= aluout;
      lmdr    <= dmem_rdata;
    end
  end

  assign imem_addr  = pc[31:2];
  assign dmem_addr  = aluout;
  assign dmem_wdata = smdr;
  assign dmem_we    = ir2[31:29] == C_ST;
  assign rt_valid   = ir3 != BUBBLE;
  assign rt_we      = wb_en;
  assign rt_reg     = wb_dst;
  assign rt_data    = wb_val;

  // R7
  ctl_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ir[31:29] == C_CTL) |-> ir1 == BUBBLE);
  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir[31:29] != C_CTL) |=> imem_addr == $past(imem_addr) + 30'd1);
  // R6
  store_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> rt_valid && !rt_we);
  // R10
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we |-> rt_reg != 5'd0);
  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> imem_addr == 30'd0 && !rt_valid && !dmem_we);
endmodule

// File: tb/tb_pipe5_core.sv
`timescale 1ns/1ps
module tb_pipe5_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [29:0] imem_addr;
  logic [31:0] imem_data, dmem_addr, dmem_wdata, dmem_rdata, rt_data;
  logic dmem_we, rt_valid, rt_we;
  logic [4:0] rt_reg;

  always #2.5 clk = ~clk;

  pipe5_core dut (.clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
    .rt_valid(rt_valid), .rt_we(rt_we), .rt_reg(rt_reg), .rt_data(rt_data));

  function automatic logic [31:0] rr(input int op, input int rd, input int s, input int t);
    return {3'b000, 3'(op), 5'(s), 5'(t), 5'(rd), 11'd0};
  endfunction
  function automatic logic [31:0] ri(input int op, input int t, input int s, input int im);
    return {3'b001, 3'(op), 5'(s), 5'(t), 16'(im)};
  endfunction
  function automatic logic [31:0] ld(input int t, input int s, input int im);
    return {6'b010000, 5'(s), 5'(t), 16'(im)};
  endfunction
  function automatic logic [31:0] st(input int t, input int s, input int im);
    return {6'b011000, 5'(s), 5'(t), 16'(im)};
  endfunction
  function automatic logic [31:0] br(input int c, input int s, input int t, input int off);
    return {3'b100, 3'(c), 5'(s), 5'(t), 16'(off)};
  endfunction

  localparam int NPROG = 35;
  localparam logic [31:0] PROG [0:NPROG-1] = '{
    ri(0,1,0,5), ri(0,2,0,-3), rr(0,3,1,2), rr(1,4,3,1), st(4,0,8), ld(5,0,8),
    ri(0,6,0,7), rr(0,7,5,6), rr(4,8,7,1), rr(6,9,1,3), ri(0,0,0,9), rr(0,10,0,1),
    br(1,1,1,3), ri(0,11,0,1), ri(0,12,0,99), ri(0,12,0,98), br(2,1,1,5), ri(0,13,0,2),
    br(0,0,0,3), rr(5,14,2,1), ri(0,15,0,55), ri(0,15,0,56), rr(7,15,2,3), rr(3,16,15,11),
    rr(2,17,16,9), st(17,0,12), ri(0,18,0,1), ri(0,18,0,2), rr(0,19,18,18), ri(0,20,0,11),
    ri(0,21,0,0), ri(0,22,0,0), rr(0,23,20,0), br(0,0,0,-1), 32'h0};

  localparam int NEXP = 23;
  localparam logic [36:0] EXP [0:NEXP-1] = '{
    {5'd1, 32'd5}, {5'd2, 32'hFFFFFFFD}, {5'd3, 32'd2}, {5'd4, 32'hFFFFFFFD},
    {5'd5, 32'hFFFFFFFD}, {5'd6, 32'd7}, {5'd7, 32'd4}, {5'd8, 32'd1}, {5'd9, 32'd20},
    {5'd10, 32'd5}, {5'd11, 32'd1}, {5'd13, 32'd2}, {5'd14, 32'd1},
    {5'd15, 32'h3FFFFFFF}, {5'd16, 32'h3FFFFFFF}, {5'd17, 32'd20},
    {5'd18, 32'd1}, {5'd18, 32'd2}, {5'd19, 32'd4}, {5'd20, 32'd11},
    {5'd21, 32'd0}, {5'd22, 32'd0}, {5'd23, 32'd11}};
  localparam string TAG [0:NEXP-1] = '{
    "R4", "R4", "R8", "R8", "R5", "R4", "R5", "R3", "R3", "R10", "R7", "R7", "R7",
    "R3", "R8", "R3", "R4", "R4", "R8", "R4", "R4", "R4", "R9"};

  logic [31:0] dmem [0:15];
  assign imem_data  = (imem_addr < 30'(NPROG)) ? PROG[imem_addr] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[5:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;

  logic mon = 1'b0;
  logic [36:0] wlog [0:31];
  int wcnt = 0, ncnt = 0;
  always @(negedge clk)
    if (mon && rt_valid) begin
      if (rt_we) begin
        if (wcnt < 32) wlog[wcnt] <= {rt_reg, rt_data};
        wcnt <= wcnt + 1;
      end else ncnt <= ncnt + 1;
    end

  int nchk = 0, nerr = 0;
  bit timeout = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run();
    for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 0, "R2 fetch addr", 64'(imem_addr), 0);
    chk(!rt_valid && !dmem_we, "R2 idle", {62'd0, rt_valid, dmem_we}, 0);
    rst_n = 1'b1;
    mon = 1'b1;
    repeat (80) @(negedge clk);
    mon = 1'b0;
    chk(wcnt == NEXP, "R11 write count", 64'(wcnt), 64'(NEXP));
    for (int i = 0; i < NEXP; i++)
      if (i < wcnt) chk(wlog[i] == EXP[i], TAG[i], 64'(wlog[i]), 64'(EXP[i]));
    chk(ncnt == 3, "R6 R10 non-writing retires", 64'(ncnt), 3);
    chk(dmem[2] == 32'hFFFFFFFD, "R6 store forwarded data", 64'(dmem[2]), 64'h FFFFFFFD);
    chk(dmem[3] == 32'd20, "R6 second store", 64'(dmem[3]), 20);
    // reset mid-run, then watch the first instruction flow
    rst_n = 1'b0;
    #1;
    chk(imem_addr == 0 && !rt_valid, "R2 async clear", {33'd0, imem_addr, rt_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(imem_addr == 1, "R1 fetch step", 64'(imem_addr), 1);
    chk(!rt_valid, "R2 edge1", 64'(rt_valid), 0);
    @(negedge clk);
    @(negedge clk);
    chk(!rt_valid, "R2 edge3", 64'(rt_valid), 0);
    @(negedge clk);
    chk(rt_valid && rt_we && rt_reg == 1 && rt_data == 5, "R1 first retire latency",
        {26'd0, rt_valid, rt_we, rt_reg, rt_data}, {26'd0, 1'b1, 1'b1, 5'd1, 32'd5});
  endtask

  initial begin
    fork
      run();
      begin #20000; timeout = 1'b1; end
    join_any
    if (timeout) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule